// File: doc/BRIEF.md
# Next-PC and Instruction Fetch Address Unit

This block owns the program counter of a simple single-issue processor and decides, once per clock, where the next fetch comes from. It presents the current fetch address to an external instruction memory. It also presents the sequential successor of that address, the fetch address plus 4, for use elsewhere in the pipeline. From the fetched instruction word it takes a 16-bit signed displacement and a 26-bit word-address field. From the rest of the processor it takes a branch enable, a jump enable and the equality flag of an operand comparison.

Three candidate addresses are formed in parallel. The first is the sequential successor. The second is a relative branch target: the 16-bit displacement is sign-extended, turned into a byte offset by shifting left two places, and added to the successor. The third is an absolute jump target: the top 4 bits of the successor, then the 26-bit field, then two zero bits. A priority selector picks one of them. The result is registered on the rising clock edge. A synchronous reset returns the counter to address 0.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `fetch_addr` becomes 0 after that edge, whatever the other inputs are.
- R2: `seq_addr` always equals `fetch_addr` plus 4, modulo 2^32.
- R3: When `jump_en` is 0, and either `branch_en` or `cmp_zero` is 0, `fetch_addr` after the edge equals `seq_addr` before the edge.
- R4: When `branch_en` is 1, `cmp_zero` is 1 and `jump_en` is 0, the next `fetch_addr` is `seq_addr` plus the byte offset. The byte offset is `instr[15:0]` sign-extended to 32 bits from bit 15 and shifted left by 2.
- R5: A branch is not taken when only one of `branch_en` and `cmp_zero` is 1. The displacement field then has no effect, and the next address is `seq_addr`.
- R6: A displacement with bit 15 set moves the fetch backwards. The value 0xFFFF gives a target equal to the current `fetch_addr`. The value 0xFFFE at address 0 gives 0xFFFFFFFC.
- R7: When `jump_en` is 1, the next `fetch_addr` is formed in three parts. Bits 31:28 are `seq_addr[31:28]`, bits 27:2 are `instr[25:0]`, and bits 1:0 are 0.
- R8: `jump_en` has priority over a taken branch. With `jump_en`, `branch_en` and `cmp_zero` all 1, the jump target is used.
- R9: The upper 4 bits of a jump target come from the sequential successor. At fetch address 0x0FFFFFFC, a jump with field 0x0000010 goes to 0x10000040.
- R10: Sequential flow wraps. From 0xFFFFFFFC, the next address is 0 and `seq_addr` is 4 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word; bits 15:0 hold the displacement, bits 25:0 the jump field |
| cmp_zero | input | 1 | Equality flag from the operand comparison |
| branch_en | input | 1 | Conditional branch control |
| jump_en | input | 1 | Absolute jump control |
| fetch_addr | output | 32 | Current program counter, the instruction fetch address |
| seq_addr | output | 32 | Current program counter plus 4 |

## Verification
The bench aims at sign extension with a negative displacement. A design that zero-extends would jump roughly 256 KB forward instead of looping on itself or stepping to 0xFFFFFFFC from address 0. It drives the jump, branch and zero inputs all at once: a wrong priority order would follow the displacement instead of the jump field. It crosses the 256 MB boundary with a jump placed at 0x0FFFFFFC, where taking the upper bits from the current counter instead of its successor lands in the wrong region. It also checks the 32-bit wrap, and that a branch enable without the flag, or the flag without the enable, leaves the sequential flow untouched.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;

    // Which candidate address the selector picked for the next cycle.
    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_src_e;

endpackage

// File: rtl/npc_seq_branch.sv
module npc_seq_branch #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int STEP   = 4,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] pc_step,
    output logic [ADDR_W-1:0] br_target
);
    localparam int EXT_W = ADDR_W - DISP_W - SHIFT;

    logic [ADDR_W-1:0] byte_off;

    // Sign extension: the displacement's top bit fills every upper position.
    generate
        if (EXT_W > 0) begin : g_ext
            assign byte_off = {{EXT_W{disp[DISP_W-1]}}, disp, {SHIFT{1'b0}}};
        end else begin : g_trunc
            logic [DISP_W+SHIFT-1:0] wide_off;
            assign wide_off = {disp, {SHIFT{1'b0}}};
            assign byte_off = wide_off[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        pc_step   = pc + ADDR_W'(STEP);
        br_target = pc_step + byte_off;
    end

endmodule

// File: rtl/npc_jump_target.sv
module npc_jump_target #(
    parameter int ADDR_W        = 32,
    parameter int FIELD_W       = 26,
    parameter int SHIFT         = 2,
    parameter bit HI_FROM_STEP  = 1'b1
) (
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  pc_step,
    input  logic [FIELD_W-1:0] field,
    output logic [ADDR_W-1:0]  jmp_target
);
    localparam int HI_W = ADDR_W - FIELD_W - SHIFT;

    logic [ADDR_W-1:0] hi_src;
    logic              unused_hi_low;

    // Variant: upper region bits from the successor or from the current counter.
    generate
        if (HI_FROM_STEP) begin : g_from_step
            assign hi_src = pc_step;
        end else begin : g_from_pc
            assign hi_src = pc;
        end
    endgenerate

    assign unused_hi_low = ^{hi_src[ADDR_W-HI_W-1:0], pc, pc_step};

    always_comb begin
        jmp_target = {hi_src[ADDR_W-1:ADDR_W-HI_W], field, {SHIFT{1'b0}}};
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import fetch_pc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] seq_target,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic              branch_en,
    input  logic              cmp_zero,
    input  logic              jump_en,
    output logic [ADDR_W-1:0] next_pc,
    output npc_src_e          src
);
    // Priority: jump, then taken branch, then sequential.
    always_comb begin
        if (jump_en) begin
            src = NPC_JUMP;
        end else if (branch_en && cmp_zero) begin
            src = NPC_BRANCH;
        end else begin
            src = NPC_SEQ;
        end
        unique case (src)
            NPC_JUMP:   next_pc = jmp_target;
            NPC_BRANCH: next_pc = br_target;
            default:    next_pc = seq_target;
        endcase
    end

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pc_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          DISP_W   = 16,
    parameter int          FIELD_W  = 26,
    parameter int          STEP     = 4,
    parameter int          SHIFT    = 2,
    parameter logic [31:0] PC_RESET = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] instr,
    input  logic              cmp_zero,
    input  logic              branch_en,
    input  logic              jump_en,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] seq_addr
);
    localparam int EXT_W = ADDR_W - DISP_W - SHIFT;
    localparam int HI_W  = ADDR_W - FIELD_W - SHIFT;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t         state_d, state_q;
    logic [ADDR_W-1:0] step_w, br_w, jmp_w, next_w;
    npc_src_e          src_w;
    logic              unused_opcode;

    assign unused_opcode = ^instr[ADDR_W-1:FIELD_W];

    npc_seq_branch #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W), .STEP(STEP), .SHIFT(SHIFT)
    ) u_seq_branch (
        .pc        (state_q.pc),
        .disp      (instr[DISP_W-1:0]),
        .pc_step   (step_w),
        .br_target (br_w)
    );

    npc_jump_target #(
        .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .SHIFT(SHIFT), .HI_FROM_STEP(1'b1)
    ) u_jump_target (
        .pc         (state_q.pc),
        .pc_step    (step_w),
        .field      (instr[FIELD_W-1:0]),
        .jmp_target (jmp_w)
    );

    npc_select #(
        .ADDR_W(ADDR_W)
    ) u_select (
        .seq_target (step_w),
        .br_target  (br_w),
        .jmp_target (jmp_w),
        .branch_en  (branch_en),
        .cmp_zero   (cmp_zero),
        .jump_en    (jump_en),
        .next_pc    (next_w),
        .src        (src_w)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc = PC_RESET[ADDR_W-1:0];
        end else begin
            state_d.pc = next_w;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign fetch_addr = state_q.pc;
    assign seq_addr   = step_w;

    // R2: successor output tracks the counter by exactly one step
    a_r2_step_tracks: assert property (@(posedge clk) disable iff (rst)
        (seq_addr - fetch_addr) == ADDR_W'(STEP));

    // R3: with no redirect, the successor becomes the new counter
    a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
        (!jump_en && !(branch_en && cmp_zero)) |=> fetch_addr == $past(seq_addr));

    // R4: taken branch lands at successor plus scaled signed displacement
    a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (!jump_en && branch_en && cmp_zero) |=>
        fetch_addr == $past(seq_addr)
                      + {{EXT_W{$past(instr[DISP_W-1])}}, $past(instr[DISP_W-1:0]), {SHIFT{1'b0}}});

    // R6: all-ones displacement keeps the counter in place
    a_r6_self_loop: assert property (@(posedge clk) disable iff (rst)
        (!jump_en && branch_en && cmp_zero && (&instr[DISP_W-1:0])) |=> $stable(fetch_addr));

    // R7 / R9: jump target layout, region bits from the successor
    a_r7_jump_layout: assert property (@(posedge clk) disable iff (rst)
        jump_en |=> (fetch_addr[SHIFT-1:0] == '0)
                 && (fetch_addr[FIELD_W+SHIFT-1:SHIFT] == $past(instr[FIELD_W-1:0]))
                 && (fetch_addr[ADDR_W-1:ADDR_W-HI_W] == $past(seq_addr[ADDR_W-1:ADDR_W-HI_W])));

    // R8: jump wins whenever it is requested
    a_r8_jump_priority: assert property (@(posedge clk) disable iff (rst)
        jump_en |-> src_w == NPC_JUMP);

endmodule

// File: tb/fetch_pc_unit_test.sv
module fetch_pc_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        cmp_zero = 1'b0;
    logic        branch_en = 1'b0;
    logic        jump_en = 1'b0;
    logic [31:0] fetch_addr;
    logic [31:0] seq_addr;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_pc = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    fetch_pc_unit uut (
        .clk(clk), .rst(rst), .instr(instr), .cmp_zero(cmp_zero),
        .branch_en(branch_en), .jump_en(jump_en),
        .fetch_addr(fetch_addr), .seq_addr(seq_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic drive(input logic r, input logic [31:0] ins, input logic br,
                         input logic zr, input logic jp, input string tag);
        logic [31:0] p4, nxt;
        rst = r; instr = ins; branch_en = br; cmp_zero = zr; jump_en = jp;
        p4 = model_pc + 32'd4;
        if (r)             nxt = 32'h0;
        else if (jp)       nxt = {p4[31:28], ins[25:0], 2'b00};
        else if (br && zr) nxt = p4 + {{14{ins[15]}}, ins[15:0], 2'b00};
        else               nxt = p4;
        model_pc = nxt;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops one expected item after every edge that has one queued.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, fetch_addr, e);
                check("R2", seq_addr, e + 32'd4);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        drive(1'b1, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, "R1");
        drive(1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, "R3");
        drive(1'b0, 32'h1234_5678, 1'b0, 1'b1, 1'b0, "R3");
        drive(1'b0, 32'h0000_0010, 1'b1, 1'b0, 1'b0, "R5");
        drive(1'b0, 32'h0000_0010, 1'b0, 1'b1, 1'b0, "R5");
        drive(1'b0, 32'h1000_0003, 1'b1, 1'b1, 1'b0, "R4");
        drive(1'b0, 32'h0000_FFFF, 1'b1, 1'b1, 1'b0, "R6");
        drive(1'b0, 32'h0000_FFF8, 1'b1, 1'b1, 1'b0, "R6");
        drive(1'b0, 32'hFC00_0100, 1'b0, 1'b0, 1'b1, "R7");
        drive(1'b0, 32'h1000_0040, 1'b1, 1'b1, 1'b1, "R8");
        drive(1'b0, 32'h0BFF_FFFF, 1'b0, 1'b0, 1'b1, "R7");
        drive(1'b0, 32'h0800_0010, 1'b0, 1'b0, 1'b1, "R9");
        drive(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, "R1");
        drive(1'b0, 32'h0000_FFFE, 1'b1, 1'b1, 1'b0, "R6");
        drive(1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, "R10");
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[29:28])
                2'd0: drive(1'b0, lfsr, 1'b0, lfsr[30], 1'b0, "R3");
                2'd1: drive(1'b0, lfsr, 1'b1, 1'b1, 1'b0, "R4");
                2'd2: drive(1'b0, lfsr, 1'b1, 1'b0, 1'b0, "R5");
                default: drive(1'b0, lfsr, lfsr[30], lfsr[31], 1'b1, "R8");
            endcase
        end
        wait (exp_q.size() == 0);
        #10;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule